// File: doc/BRIEF.md
# VLIW Execute-Packet Issue Checker

This block decides whether one execute packet of a dual-datapath VLIW core obeys the issue rules for memory access and for wide results. Each packet holds up to eight decoded slots. For every slot the block receives the following fields:

- a valid bit
- a functional-unit class and the datapath side of that unit
- load and store flags
- the register-file side of the address register
- the register-file side of the data register
- a flag that marks a 40-bit register-pair result

The checker applies three independent rules and raises one flag for each rule that is broken. It reports the lowest slot that takes part in any violation. It also reports which register files receive a long write in the first execute cycle of the packet.

The block samples its inputs when the packet strobe is high. One clock later it presents the registered verdict together with a one-cycle result-valid pulse. The outputs keep their values until the next strobe.

Top module: `vliw_packet_checker`

## Requirements
- R1: For a valid slot with its load or store flag set, the address side must equal the unit side (side bit: 0 = A file, 1 = B file). Any mismatch sets `err_addr_side`.
- R2: For a load or store, a data-register side opposite to its address side is legal when it is the only memory access in the packet.
- R3: Two or more valid load/store slots whose data sides are equal set `err_data_file`. Loads and stores are counted together.
- R4: Load/store slots whose data registers are in different files do not conflict. This covers a load to B with a store from A, and two loads to different files.
- R5: Two or more valid slots that have the long flag set, run on an L or S unit (unit code L=0, S=1, M=2, D=3) and share a side set `err_long_write`. The long flag is ignored on M and D units.
- R6: `long_wr_files` bit 0 is set when any qualifying long slot is on side A. Bit 1 is set when any qualifying long slot is on side B.
- R7: Slots whose valid bit is 0 take part in no rule. A packet with no valid slot is legal.
- R8: `pkt_legal` is high exactly when none of the three error flags is set.
- R9: `first_bad_valid` is high when any violation exists. `first_bad_idx` then gives the lowest slot number among all offending slots.
- R10: The results appear on the clock edge after the one that samples `pkt_strobe` high, and `res_valid` pulses for that single cycle. When the strobe is low the outputs hold and the inputs have no effect.
- R11: After a synchronous active-low reset the outputs read as follows: `res_valid` low, all error flags low, `pkt_legal` high, `first_bad_valid` low, `first_bad_idx` zero and `long_wr_files` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_strobe | input | 1 | Sample the slot fields this cycle |
| slot_valid | input | 8 | Per-slot valid bit |
| slot_unit | input | 16 | Per-slot unit class, 2 bits per slot (slot i at [2i+1:2i]) |
| slot_side | input | 8 | Per-slot unit side, 0 = A, 1 = B |
| slot_load | input | 8 | Per-slot load flag |
| slot_store | input | 8 | Per-slot store flag |
| slot_addr_side | input | 8 | Per-slot address-register file side |
| slot_data_side | input | 8 | Per-slot data-register file side |
| slot_long | input | 8 | Per-slot long-result flag |
| res_valid | output | 1 | One-cycle pulse marking a fresh verdict |
| pkt_legal | output | 1 | Packet meets every rule |
| err_addr_side | output | 1 | Address-side rule broken |
| err_data_file | output | 1 | Data-file rule broken |
| err_long_write | output | 1 | Long-write rule broken |
| first_bad_valid | output | 1 | An offending slot exists |
| first_bad_idx | output | 3 | Lowest offending slot number |
| long_wr_files | output | 2 | Files receiving a long write (bit 0 = A, bit 1 = B) |

## Verification
The assertions assume that `pkt_strobe` is low while reset is asserted. They also assume that reset is held for several clocks before release, so that every registered output has a defined previous value when the hold and pulse properties begin. The bench drives inputs and the strobe only at falling edges and holds reset low for five clocks. Between packets it keeps the strobe low while it scrambles the slot fields, which exercises the hold property under changing inputs.

// File: rtl/vliw_chk_pkg.sv
// Package: shared unit-class encoding and width helpers for the packet checker.
// Assumes: two datapath sides, side bit 0 = A file, 1 = B file.
package vliw_chk_pkg;

    typedef enum logic [1:0] {
        UNIT_L = 2'd0,
        UNIT_S = 2'd1,
        UNIT_M = 2'd2,
        UNIT_D = 2'd3
    } unit_e;

    localparam int unsigned UNIT_W = 2;
    localparam int unsigned NUM_FILES = 2;

endpackage

// File: rtl/vliw_ls_rules.sv
// Module: memory-access rules. Flags slots whose address side differs from
// the unit side, and slots that share a data-register file with another
// memory access. Assumes: purely combinational, masks are per slot.
module vliw_ls_rules #(
    parameter int unsigned NUM_SLOTS = 8
) (
    input  logic [NUM_SLOTS-1:0] slot_valid,
    input  logic [NUM_SLOTS-1:0] slot_side,
    input  logic [NUM_SLOTS-1:0] slot_load,
    input  logic [NUM_SLOTS-1:0] slot_store,
    input  logic [NUM_SLOTS-1:0] slot_addr_side,
    input  logic [NUM_SLOTS-1:0] slot_data_side,
    output logic [NUM_SLOTS-1:0] addr_bad_mask,
    output logic [NUM_SLOTS-1:0] data_bad_mask
);

    logic [NUM_SLOTS-1:0] mem_slot;
    logic [NUM_SLOTS-1:0] data_in_a;
    logic [NUM_SLOTS-1:0] data_in_b;
    logic                 multi_a;
    logic                 multi_b;

    // Qualify memory accesses and split them by data-register file.
    always_comb begin
        mem_slot  = slot_valid & (slot_load | slot_store);
        data_in_a = mem_slot & ~slot_data_side;
        data_in_b = mem_slot &  slot_data_side;
    end

    // A vector holds two or more set bits when clearing its lowest bit leaves some.
    always_comb begin
        multi_a = |(data_in_a & (data_in_a - 1'b1));
        multi_b = |(data_in_b & (data_in_b - 1'b1));
    end

    // Build the offending-slot masks for both memory rules.
    always_comb begin
        addr_bad_mask = mem_slot & (slot_addr_side ^ slot_side);
        data_bad_mask = (multi_a ? data_in_a : '0) | (multi_b ? data_in_b : '0);
    end

endmodule

// File: rtl/vliw_long_rules.sv
// Module: long-result rule. A long result on an L or S unit uses the single
// wide write port of its side; two on one side conflict. Long flags on M or
// D units are ignored. Assumes: combinational, unit code from vliw_chk_pkg.
module vliw_long_rules
    import vliw_chk_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8
) (
    input  logic [NUM_SLOTS-1:0]        slot_valid,
    input  logic [NUM_SLOTS*UNIT_W-1:0] slot_unit,
    input  logic [NUM_SLOTS-1:0]        slot_side,
    input  logic [NUM_SLOTS-1:0]        slot_long,
    output logic [NUM_SLOTS-1:0]        long_bad_mask,
    output logic [NUM_FILES-1:0]        long_files
);

    logic [NUM_SLOTS-1:0] ls_unit;
    logic [NUM_SLOTS-1:0] wide_a;
    logic [NUM_SLOTS-1:0] wide_b;

    // Decode per slot whether the unit owns the shared wide write port.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unit
        unit_e u;
        assign u = unit_e'(slot_unit[g*UNIT_W +: UNIT_W]);
        assign ls_unit[g] = (u == UNIT_L) || (u == UNIT_S);
    end

    // Split qualifying long writers by destination side.
    always_comb begin
        wide_a = slot_valid & slot_long & ls_unit & ~slot_side;
        wide_b = slot_valid & slot_long & ls_unit &  slot_side;
    end

    // Report the sides written and the slots that overload a side.
    always_comb begin
        long_files[0] = |wide_a;
        long_files[1] = |wide_b;
        long_bad_mask = (|(wide_a & (wide_a - 1'b1)) ? wide_a : '0)
                      | (|(wide_b & (wide_b - 1'b1)) ? wide_b : '0);
    end

endmodule

// File: rtl/vliw_first_slot.sv
// Module: priority encoder returning the lowest set position of a mask.
// Assumes: idx is zero when no bit is set.
module vliw_first_slot #(
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0] mask,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);

    // Scan from the top so the lowest set slot wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vliw_packet_checker.sv
// Module: top of the execute-packet issue checker. Combines the memory and
// long-result rules, locates the first offending slot and registers the
// verdict one clock after pkt_strobe. Assumes: synchronous active-low reset,
// strobe low during reset.
module vliw_packet_checker
    import vliw_chk_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pkt_strobe,
    input  logic [NUM_SLOTS-1:0]        slot_valid,
    input  logic [NUM_SLOTS*UNIT_W-1:0] slot_unit,
    input  logic [NUM_SLOTS-1:0]        slot_side,
    input  logic [NUM_SLOTS-1:0]        slot_load,
    input  logic [NUM_SLOTS-1:0]        slot_store,
    input  logic [NUM_SLOTS-1:0]        slot_addr_side,
    input  logic [NUM_SLOTS-1:0]        slot_data_side,
    input  logic [NUM_SLOTS-1:0]        slot_long,
    output logic                        res_valid,
    output logic                        pkt_legal,
    output logic                        err_addr_side,
    output logic                        err_data_file,
    output logic                        err_long_write,
    output logic                        first_bad_valid,
    output logic [IDX_W-1:0]            first_bad_idx,
    output logic [NUM_FILES-1:0]        long_wr_files
);

    logic [NUM_SLOTS-1:0] addr_bad_mask;
    logic [NUM_SLOTS-1:0] data_bad_mask;
    logic [NUM_SLOTS-1:0] long_bad_mask;
    logic [NUM_SLOTS-1:0] any_bad_mask;
    logic [NUM_FILES-1:0] long_files_c;
    logic                 first_found_c;
    logic [IDX_W-1:0]     first_idx_c;

    vliw_ls_rules #(.NUM_SLOTS(NUM_SLOTS)) u_ls_rules (
        .slot_valid     (slot_valid),
        .slot_side      (slot_side),
        .slot_load      (slot_load),
        .slot_store     (slot_store),
        .slot_addr_side (slot_addr_side),
        .slot_data_side (slot_data_side),
        .addr_bad_mask  (addr_bad_mask),
        .data_bad_mask  (data_bad_mask)
    );

    vliw_long_rules #(.NUM_SLOTS(NUM_SLOTS)) u_long_rules (
        .slot_valid    (slot_valid),
        .slot_unit     (slot_unit),
        .slot_side     (slot_side),
        .slot_long     (slot_long),
        .long_bad_mask (long_bad_mask),
        .long_files    (long_files_c)
    );

    // Merge all offending slots for the first-slot search.
    always_comb begin
        any_bad_mask = addr_bad_mask | data_bad_mask | long_bad_mask;
    end

    vliw_first_slot #(.NUM_SLOTS(NUM_SLOTS)) u_first_slot (
        .mask  (any_bad_mask),
        .found (first_found_c),
        .idx   (first_idx_c)
    );

    // Pulse res_valid one clock after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= pkt_strobe;
    end

    // Capture the verdict on a strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_legal       <= 1'b1;
            err_addr_side   <= 1'b0;
            err_data_file   <= 1'b0;
            err_long_write  <= 1'b0;
            first_bad_valid <= 1'b0;
            first_bad_idx   <= '0;
            long_wr_files   <= '0;
        end else if (pkt_strobe) begin
            err_addr_side   <= |addr_bad_mask;
            err_data_file   <= |data_bad_mask;
            err_long_write  <= |long_bad_mask;
            pkt_legal       <= ~(|addr_bad_mask | |data_bad_mask | |long_bad_mask);
            first_bad_valid <= first_found_c;
            first_bad_idx   <= first_idx_c;
            long_wr_files   <= long_files_c;
        end
    end

    // R10: a result pulse follows every strobe and only a strobe.
    a_r10_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_strobe |=> res_valid);
    a_r10_no_pulse_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_strobe |=> !res_valid);

    // R10: without a strobe the verdict holds.
    a_r10_hold_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_strobe |=> ($stable(pkt_legal) && $stable(first_bad_valid)
                         && $stable(first_bad_idx) && $stable(long_wr_files)));

    // R9: a located offending slot exists exactly when the packet is illegal.
    a_r9_first_matches_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        first_bad_valid == !pkt_legal);

    // R6: a long-write conflict implies at least one file is written long.
    a_r6_conflict_has_file: assert property (@(posedge clk) disable iff (!rst_n)
        err_long_write |-> (long_wr_files != '0));

    // R3: a data-file conflict always locates an offending slot.
    a_r3_conflict_located: assert property (@(posedge clk) disable iff (!rst_n)
        err_data_file |-> first_bad_valid);

endmodule

// File: tb/vliw_packet_checker_tb_top.sv
// Bench: behavioural reference model of the issue rules, compared against the
// registered outputs on every clock.
module vliw_packet_checker_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pkt_strobe = 1'b0;
    logic [N-1:0]   slot_valid = '0;
    logic [2*N-1:0] slot_unit = '0;
    logic [N-1:0]   slot_side = '0;
    logic [N-1:0]   slot_load = '0;
    logic [N-1:0]   slot_store = '0;
    logic [N-1:0]   slot_addr_side = '0;
    logic [N-1:0]   slot_data_side = '0;
    logic [N-1:0]   slot_long = '0;
    logic         res_valid;
    logic         pkt_legal;
    logic         err_addr_side;
    logic         err_data_file;
    logic         err_long_write;
    logic         first_bad_valid;
    logic [2:0]   first_bad_idx;
    logic [1:0]   long_wr_files;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state (expected registered outputs).
    int e_rv = 0, e_legal = 1, e_ea = 0, e_ed = 0, e_el = 0, e_fv = 0, e_fi = 0, e_lf = 0;

    always #4 clk = ~clk;

    vliw_packet_checker dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_strobe(pkt_strobe),
        .slot_valid(slot_valid), .slot_unit(slot_unit), .slot_side(slot_side),
        .slot_load(slot_load), .slot_store(slot_store),
        .slot_addr_side(slot_addr_side), .slot_data_side(slot_data_side),
        .slot_long(slot_long), .res_valid(res_valid), .pkt_legal(pkt_legal),
        .err_addr_side(err_addr_side), .err_data_file(err_data_file),
        .err_long_write(err_long_write), .first_bad_valid(first_bad_valid),
        .first_bad_idx(first_bad_idx), .long_wr_files(long_wr_files)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Evaluate the rules on the current inputs, slot by slot, with counters.
    task automatic model_eval();
        int na = 0, nb = 0, la = 0, lb = 0;
        int bad[N];
        int addr_bad = 0;
        e_ea = 0; e_ed = 0; e_el = 0; e_fv = 0; e_fi = 0; e_lf = 0;
        for (int i = 0; i < N; i++) begin
            bad[i] = 0;
            if (slot_valid[i] && (slot_load[i] || slot_store[i])) begin
                if (slot_data_side[i]) nb++; else na++;
                if (slot_addr_side[i] != slot_side[i]) begin bad[i] = 1; addr_bad = 1; end
            end
            if (slot_valid[i] && slot_long[i] && slot_unit[2*i+1] == 1'b0) begin
                if (slot_side[i]) lb++; else la++;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (slot_valid[i] && (slot_load[i] || slot_store[i])) begin
                if ((slot_data_side[i] && nb > 1) || (!slot_data_side[i] && na > 1)) bad[i] = 1;
            end
            if (slot_valid[i] && slot_long[i] && slot_unit[2*i+1] == 1'b0) begin
                if ((slot_side[i] && lb > 1) || (!slot_side[i] && la > 1)) bad[i] = 1;
            end
        end
        e_ea = addr_bad;
        e_ed = (na > 1 || nb > 1) ? 1 : 0;
        e_el = (la > 1 || lb > 1) ? 1 : 0;
        e_lf = (la > 0 ? 1 : 0) + (lb > 0 ? 2 : 0);
        e_legal = (e_ea || e_ed || e_el) ? 0 : 1;
        for (int i = N - 1; i >= 0; i--) if (bad[i]) begin e_fv = 1; e_fi = i; end
    endtask

    task automatic compare_all(input string req);
        chk(req, "res_valid", int'(res_valid), e_rv);
        chk(req, "pkt_legal", int'(pkt_legal), e_legal);
        chk(req, "err_addr_side", int'(err_addr_side), e_ea);
        chk(req, "err_data_file", int'(err_data_file), e_ed);
        chk(req, "err_long_write", int'(err_long_write), e_el);
        chk(req, "first_bad_valid", int'(first_bad_valid), e_fv);
        chk(req, "first_bad_idx", int'(first_bad_idx), e_fi);
        chk(req, "long_wr_files", int'(long_wr_files), e_lf);
    endtask

    task automatic clear_slots();
        slot_valid = '0; slot_unit = '0; slot_side = '0; slot_load = '0;
        slot_store = '0; slot_addr_side = '0; slot_data_side = '0; slot_long = '0;
    endtask

    // Set one slot: unit code 0..3, side, load, store, address side, data side, long.
    task automatic set_slot(input int i, input int u, input bit sd, input bit ld,
                            input bit st, input bit asd, input bit dsd, input bit lg);
        slot_valid[i] = 1'b1;
        slot_unit[2*i +: 2] = 2'(u);
        slot_side[i] = sd; slot_load[i] = ld; slot_store[i] = st;
        slot_addr_side[i] = asd; slot_data_side[i] = dsd; slot_long[i] = lg;
    endtask

    // Strobe the current packet at a falling edge; check after the next edge,
    // then check that the pulse drops and the verdict holds.
    task automatic send(input string req);
        model_eval();
        pkt_strobe = 1'b1;
        @(negedge clk);
        pkt_strobe = 1'b0;
        e_rv = 1;
        compare_all(req);
        slot_valid = ~slot_valid; slot_side = ~slot_side; slot_long = ~slot_long;
        @(negedge clk);
        e_rv = 0;
        compare_all({req, " R10 hold"});
    endtask

    localparam int UL = 0, US = 1, UM = 2, UD = 3;

    initial begin
        repeat (5) @(negedge clk);
        // R11: reset state.
        compare_all("R11 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R11 after release");

        // R7: empty packet is legal.
        clear_slots(); send("R7 empty");

        // R1: D2 using an A-file address.
        clear_slots(); set_slot(0, UD, 0, 1, 0, 0, 0, 0); set_slot(1, UD, 1, 1, 0, 0, 1, 0);
        send("R1 addr mismatch");
        // R1: both address files correct.
        clear_slots(); set_slot(0, UD, 0, 1, 0, 0, 0, 0); set_slot(1, UD, 1, 1, 0, 1, 1, 0);
        send("R1 addr ok");
        // R2: lone crossing load.
        clear_slots(); set_slot(4, UD, 0, 1, 0, 0, 1, 0); send("R2 lone crossing");
        // R3: load to A plus store from A.
        clear_slots(); set_slot(2, UD, 0, 1, 0, 0, 0, 0); set_slot(5, UD, 1, 0, 1, 1, 0, 0);
        send("R3 load+store same file");
        // R4: load to B with store from A.
        clear_slots(); set_slot(0, UD, 0, 1, 0, 0, 1, 0); set_slot(1, UD, 1, 0, 1, 1, 0, 0);
        send("R4 load B store A");
        // R4: two loads to different files.
        clear_slots(); set_slot(3, UD, 0, 1, 0, 0, 1, 0); set_slot(6, UD, 1, 1, 0, 1, 0, 0);
        send("R4 loads split");
        // R5/R6: two long results on side A (L and S units).
        clear_slots(); set_slot(1, UL, 0, 0, 0, 0, 0, 1); set_slot(6, US, 0, 0, 0, 0, 0, 1);
        send("R5 long conflict A");
        // R5/R6: one long per side is legal, both files reported.
        clear_slots(); set_slot(1, UL, 0, 0, 0, 0, 0, 1); set_slot(2, US, 1, 0, 0, 0, 0, 1);
        send("R6 long both files");
        // R5: long flag on M and D units ignored.
        clear_slots(); set_slot(0, UM, 0, 0, 0, 0, 0, 1); set_slot(1, UD, 0, 0, 0, 0, 0, 1);
        set_slot(2, UL, 0, 0, 0, 0, 0, 1); send("R5 M/D long ignored");
        // R7: invalid slots ignored even if they would conflict.
        clear_slots(); set_slot(0, UD, 0, 1, 0, 0, 0, 0); set_slot(1, UD, 0, 1, 0, 1, 0, 1);
        slot_valid[1] = 1'b0; send("R7 invalid ignored");
        // R9: lowest offending slot across rules (long on 3,5 and address on 7).
        clear_slots(); set_slot(7, UD, 0, 1, 0, 1, 0, 0);
        set_slot(5, US, 1, 0, 0, 0, 0, 1); set_slot(3, UL, 1, 0, 0, 0, 0, 1);
        send("R9 first slot");
        // R8: all three flags together.
        clear_slots(); set_slot(0, UD, 1, 1, 0, 0, 1, 0); set_slot(4, UD, 0, 0, 1, 0, 1, 0);
        set_slot(5, UL, 0, 0, 0, 0, 0, 1); set_slot(6, US, 0, 0, 0, 0, 0, 1);
        send("R8 all flags");

        // R1-style mixed patterns: pseudo-random packets against the model (R8, R9).
        for (int k = 0; k < 300; k++) begin
            slot_valid = N'($urandom); slot_unit = (2*N)'($urandom);
            slot_side = N'($urandom); slot_load = N'($urandom) & N'($urandom);
            slot_store = N'($urandom) & N'($urandom) & ~slot_load;
            slot_addr_side = slot_side ^ (N'($urandom) & N'($urandom) & N'($urandom));
            slot_data_side = N'($urandom); slot_long = N'($urandom);
            send("R8 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule